// File: doc/BRIEF.md
# Status-Register Write Guard

This block is the serial front end that protects the status register of a small flash-style device. A host frames each instruction by pulling the active-low chip enable low, clocking bytes in on the serial data input most significant bit first on rising serial-clock edges, and releasing chip enable. All pins are oversampled on the device's system clock through synchronizers, so serial clock mode 0 (idle low) and mode 3 (idle high) are handled alike.

Changing the protection bits takes two instructions in a row. First comes a one-byte unlock opcode 0x50. Then a write opcode 0x01 and one data byte. The new values are applied when chip enable rises at the end of the write frame. The write-protect pin and the current lock bit decide whether the write is applied. While the pin is low, a set lock bit freezes the register. A clear lock bit may still be set, but never cleared.

The current status byte is always visible on a read-back port. The serial data output is never driven by the instructions handled here.

Top module: `sr_write_guard`

## Requirements
- R1: An asynchronous active-low reset clears the whole status byte to 0x00.
- R2: A write frame (first byte 0x01) is ignored unless the instruction just before it was the unlock 0x50. Any other instruction in between cancels the unlock. Any frame of at least one clock counts as an instruction.
- R3: An accepted write is applied at the chip-enable rising edge that ends it. The read-back shows the new value no later than 4 system clocks after that edge is sampled.
- R4: Field positions: block-protect 0 is status bit 2, block-protect 1 is bit 3, and the lock bit is bit 7. All other status bits read 0 whatever the data byte holds.
- R5: With write-protect high at the end of the frame, all three protection bits are copied from the data byte, and the lock bit may be cleared.
- R6: With write-protect low and the lock bit 1, a write leaves the status byte unchanged.
- R7: With write-protect low and the lock bit 0, one write may set the lock bit and both block-protect bits together.
- R8: The lock bit never goes from 1 to 0 while write-protect is low.
- R9: The serial output enable `soOe` stays 0 throughout.
- R10: Bytes are taken MSB first on rising serial-clock edges. Serial clock mode 0 and mode 3 framing give the same result.
- R11: A write frame with other than exactly 16 clocks is discarded, and the unlock is consumed in any case.
- R12: The status byte changes only as a result of a chip-enable rising edge, never in the middle of a frame.
- R13: Write-protect is judged at the same sampled cycle as the chip-enable rise. A write-protect change applied at the same instant as the rise is the one in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the pins |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sck | input | 1 | Serial clock pin |
| ceN | input | 1 | Active-low chip enable pin |
| si | input | 1 | Serial data input pin |
| wp | input | 1 | Write-protect pin, active low |
| soOe | output | 1 | Serial output enable, held low (output in high impedance) |
| statusOut | output | 8 | Read-back of the status register |

## Verification
The commit at the end of a write frame and the sampling of the write-protect pin fall in the same cycle. Both pins pass through synchronizers of the same depth, so their sampled edges line up. The bench provokes this by locking the register with write-protect low. It then ends an unlocked write frame while raising write-protect at the very instant chip enable rises. The write must be accepted, because the pin level that counts is the one sampled together with the chip-enable rise.

// File: rtl/srwg_pkg.sv
package srwg_pkg;
  localparam logic [7:0] OPC_UNLOCK = 8'h50;
  localparam logic [7:0] OPC_WRITE  = 8'h01;
  localparam int BYTE_BITS  = 8;
  localparam int FRAME_BITS = 2 * BYTE_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int BP0_POS    = 2;
  localparam int BP1_POS    = 3;
  localparam int LOCK_POS   = 7;

  typedef enum logic [1:0] {
    INS_NONE   = 2'd0,
    INS_UNLOCK = 2'd1,
    INS_WRITE  = 2'd2,
    INS_OTHER  = 2'd3
  } insKind_t;

  typedef struct packed {
    logic shiftEn;
    logic commit;
  } strobe_t;

  function automatic insKind_t decodeOp(input logic [7:0] op);
    if (op == OPC_UNLOCK)     return INS_UNLOCK;
    else if (op == OPC_WRITE) return INS_WRITE;
    else                      return INS_OTHER;
  endfunction
endpackage

// File: rtl/srwg_sync.sv
module srwg_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= RST_VAL;
        else       stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= RST_VAL;
        else       stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/srwg_ctrl.sv
module srwg_ctrl
  import srwg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sckS,
  input  logic             ceNS,
  input  logic [7:0]       nextByte,
  output strobe_t          strobe,
  output logic             ceEnd,
  output logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_OPC  = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic     sckPrev;
  logic     ceNPrev;
  logic     sckRise;
  logic     ceStart;
  insKind_t insKind;
  logic     unlockPending;

  assign sckRise = sckS & ~sckPrev & ~ceNS;
  assign ceStart = ~ceNS & ceNPrev;
  assign ceEnd   = ceNS & ~ceNPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      ceNPrev <= 1'b1;
    end else begin
      sckPrev <= sckS;
      ceNPrev <= ceNS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      insKind <= INS_NONE;
    end else if (ceStart) begin
      bitCnt  <= '0;
      insKind <= INS_NONE;
    end else if (sckRise) begin
      if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
      if (bitCnt == CNT_OPC) insKind <= decodeOp(nextByte);
    end
  end

  // The unlock lives for exactly one following instruction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         unlockPending <= 1'b0;
    else if (ceEnd && bitCnt != '0)    unlockPending <= (insKind == INS_UNLOCK);
  end

  always_comb begin
    strobe.shiftEn = sckRise;
    strobe.commit  = ceEnd && unlockPending && (insKind == INS_WRITE)
                     && (bitCnt == CNT_FULL);
  end
endmodule

// File: rtl/srwg_dp.sv
module srwg_dp
  import srwg_pkg::*;
#(
  parameter logic [7:0] RO_VALUE = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobe,
  input  logic       siS,
  input  logic       wpS,
  output logic [7:0] nextByte,
  output logic [7:0] statusOut
);
  logic [7:0] shiftReg;
  logic       lockBit;
  logic       bp0Bit;
  logic       bp1Bit;
  logic       writeOk;

  assign nextByte = {shiftReg[6:0], siS};
  assign writeOk  = wpS | ~lockBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= nextByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit <= 1'b0;
      bp0Bit  <= 1'b0;
      bp1Bit  <= 1'b0;
    end else if (strobe.commit && writeOk) begin
      lockBit <= shiftReg[LOCK_POS];
      bp0Bit  <= shiftReg[BP0_POS];
      bp1Bit  <= shiftReg[BP1_POS];
    end
  end

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (i == LOCK_POS)     statusOut[i] = lockBit;
      else if (i == BP1_POS) statusOut[i] = bp1Bit;
      else if (i == BP0_POS) statusOut[i] = bp0Bit;
      else                   statusOut[i] = RO_VALUE[i];
    end
  end
endmodule

// File: rtl/sr_write_guard.sv
module sr_write_guard
  import srwg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       ceN,
  input  logic       si,
  input  logic       wp,
  output logic       soOe,
  output logic [7:0] statusOut
);
  logic             sckS;
  logic             ceNS;
  logic             siS;
  logic             wpS;
  logic [7:0]       nextByte;
  strobe_t          strobe;
  logic             ceEnd;
  logic [CNT_W-1:0] bitCnt;

  srwg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({sck, ceN, si, wp}),
    .dout({sckS, ceNS, siS, wpS})
  );

  srwg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sckS    (sckS),
    .ceNS    (ceNS),
    .nextByte(nextByte),
    .strobe  (strobe),
    .ceEnd   (ceEnd),
    .bitCnt  (bitCnt)
  );

  srwg_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .siS      (siS),
    .wpS      (wpS),
    .nextByte (nextByte),
    .statusOut(statusOut)
  );

  assign soOe = 1'b0;
endmodule

// File: rtl/srwg_chk.sv
module srwg_chk
  import srwg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       statusOut,
  input logic             wpS,
  input logic             ceEnd,
  input logic [CNT_W-1:0] bitCnt
);
  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[LOCK_POS]) |-> $past(wpS));

  // R12
  change_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut != $past(statusOut)) |-> $past(ceEnd));

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[LOCK_POS] && !wpS) |=> $stable(statusOut));

  // R11
  full_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut != $past(statusOut)) |-> $past(bitCnt == CNT_W'(FRAME_BITS)));
endmodule

bind sr_write_guard srwg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .statusOut(statusOut),
  .wpS      (wpS),
  .ceEnd    (ceEnd),
  .bitCnt   (bitCnt)
);

// File: tb/sr_write_guard_test.sv
module sr_write_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4 * CLK_PERIOD;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0;
  logic       ceN = 1'b1;
  logic       si = 1'b0;
  logic       wp = 1'b1;
  logic       soOe;
  logic [7:0] statusOut;

  int   checks = 0;
  int   failures = 0;
  bit   soSeen = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] midStatus;

  sr_write_guard uut (
    .clk(clk), .rstN(rstN), .sck(sck), .ceN(ceN), .si(si), .wp(wp),
    .soOe(soOe), .statusOut(statusOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rstN && soOe) soSeen = 1'b1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // One chip-enable frame; wpEnd >= 0 changes wp at the instant ceN rises.
  task automatic xfer(input logic [23:0] word, input int nbits, input bit mode3,
                      input int wpEnd);
    sck = mode3;
    #(HALF);
    ceN = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (mode3) begin
        sck = 1'b0; si = word[nbits-1-i]; #(HALF); sck = 1'b1; #(HALF);
      end else begin
        si = word[nbits-1-i]; #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
      end
    end
    #(HALF);
    midStatus = statusOut;
    ceN = 1'b1;
    if (wpEnd >= 0) wp = wpEnd[0];
    #(CLK_PERIOD * 8);
  endtask

  task automatic unlock(input bit mode3);
    xfer({16'h0, 8'h50}, 8, mode3, -1);
  endtask

  task automatic wr(input logic [7:0] data, input bit mode3, input int wpEnd);
    xfer({8'h0, 8'h01, data}, 16, mode3, wpEnd);
  endtask

  task automatic setWp(input logic v);
    wp = v;
    #(CLK_PERIOD * 6);
  endtask

  task automatic t_reset;
    check("R1 reset status", statusOut, 8'h00);
    check("R9 soOe after reset", {7'h0, soOe}, 8'h00);
  endtask

  task automatic t_noUnlock;
    setWp(1'b1);
    wr(8'h8C, 1'b0, -1);
    check("R2 write without unlock", statusOut, 8'h00);
  endtask

  task automatic t_basic;
    unlock(1'b0);
    wr(8'h0C, 1'b0, -1);
    check("R3 R10 unlocked write mode0", statusOut, 8'h0C);
  endtask

  task automatic t_roBits;
    unlock(1'b0);
    wr(8'h73, 1'b0, -1);
    check("R4 read-only bits stay 0", statusOut, 8'h00);
    unlock(1'b0);
    wr(8'hFF, 1'b0, -1);
    check("R4 R5 lock and bp together", statusOut, 8'h8C);
  endtask

  task automatic t_cancel;
    unlock(1'b0);
    xfer({16'h0, 8'h05}, 8, 1'b0, -1);
    wr(8'h00, 1'b0, -1);
    check("R2 other instruction cancels unlock", statusOut, 8'h8C);
  endtask

  task automatic t_locked;
    setWp(1'b0);
    unlock(1'b0);
    wr(8'h00, 1'b0, -1);
    check("R6 R8 locked and wp low ignores write", statusOut, 8'h8C);
  endtask

  task automatic t_wpHigh;
    setWp(1'b1);
    unlock(1'b0);
    wr(8'h00, 1'b0, -1);
    check("R5 wp high clears lock", statusOut, 8'h00);
  endtask

  task automatic t_setLock;
    setWp(1'b0);
    unlock(1'b0);
    wr(8'h88, 1'b0, -1);
    check("R7 wp low sets lock and bp1", statusOut, 8'h88);
    unlock(1'b0);
    wr(8'h04, 1'b0, -1);
    check("R8 lock not cleared with wp low", statusOut, 8'h88);
  endtask

  task automatic t_race;
    unlock(1'b0);
    wr(8'h04, 1'b0, 1);
    check("R13 wp rise with ce rise accepted", statusOut, 8'h04);
  endtask

  task automatic t_mode3;
    setWp(1'b1);
    unlock(1'b1);
    wr(8'h08, 1'b1, -1);
    check("R10 mode3 write", statusOut, 8'h08);
  endtask

  task automatic t_badLength;
    unlock(1'b0);
    xfer({8'h0, 16'h010C} >> 1, 15, 1'b0, -1);
    check("R11 short write discarded", statusOut, 8'h08);
    wr(8'h0C, 1'b0, -1);
    check("R11 unlock consumed by short write", statusOut, 8'h08);
    unlock(1'b0);
    xfer({7'h0, 16'h010C, 1'b1}, 17, 1'b0, -1);
    check("R11 long write discarded", statusOut, 8'h08);
  endtask

  task automatic t_midFrame;
    unlock(1'b0);
    wr(8'h0C, 1'b0, -1);
    check("R12 unchanged before ce rise", midStatus, 8'h08);
    check("R12 R3 applied after ce rise", statusOut, 8'h0C);
  endtask

  task automatic t_so;
    check("R9 soOe never driven", {7'h0, soSeen}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 3 + CLK_PERIOD / 2);
    rstN = 1'b1;
    #(CLK_PERIOD * 4);
    t_reset();
    t_noUnlock();
    t_basic();
    t_roBits();
    t_cancel();
    t_locked();
    t_wpHigh();
    t_setLock();
    t_race();
    t_mode3();
    t_badLength();
    t_midFrame();
    t_so();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end
endmodule